// File: doc/BRIEF.md
# Stream-to-Memory Write Adapter

This block drains a flow-controlled stream of result words from a processing unit into one memory bank. Software sets a base word address and a word count through a small register window. Writing the count arms the adapter at once; there is no separate start bit. The adapter then accepts stream words one at a time and turns each into an addressed write on a request/acknowledge memory port. While a write waits for its acknowledge, the adapter holds the producer off.

Each acknowledged write advances the target address by one word and bumps a words-written counter. Software can read that counter at any time to follow progress. When the counter reaches the programmed count, the adapter stops taking data, raises a done flag and stays idle until software writes a new count. A typical job is 256 words. In a larger control map, each adapter instance sits in its own window, and the window decode lives outside this block.

Top module: `stream_mem_writer`

## Requirements
- R1: After reset, s_ready, m_req and xfer_done are 0, and reads of the word-count (offset 0) and status (offset 3) registers return 0.
- R2: The register window is word-indexed by reg_addr. Offset 0 reads the words-written count and is read-only. Offset 1 is the base word address (read/write). Offset 2 is the transfer length in words (read/write). Offset 3 is status (read-only): bit 0 is done and bit 1 is busy. Writes to offsets 0 and 3 change nothing.
- R3: A write to offset 2 while idle arms the adapter: the count clears, and with a nonzero length busy=1 and s_ready=1 from the next cycle. A length of 0 sets done at once, with no memory write.
- R4: A stream word taken on a cycle with s_valid and s_ready both high appears in the next cycle as m_req=1, with m_wdata equal to that word and m_addr equal to base plus the number of writes already acknowledged.
- R5: While m_req is high and m_ack is low, s_ready is 0, and m_req, m_addr and m_wdata hold their values.
- R6: Each cycle with m_req and m_ack both high ends that write and adds one to the words-written count. The next write address is one higher, wrapping modulo 2^ADDR_W.
- R7: When the count reaches the length, s_ready drops, busy clears and done (status bit 0 and xfer_done) rises. Stream data offered after that produces no memory write and leaves the count unchanged.
- R8: Writes to the base or length register while busy are ignored: the readback values and the ongoing transfer are unchanged.
- R9: Writing a new length after done clears done and the count, and starts a fresh transfer at the current base register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset within the window |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data (combinational from reg_addr) |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Adapter can take a stream word |
| s_data | input | DATA_W | Stream word |
| m_req | output | 1 | Memory write request |
| m_ack | input | 1 | Memory write acknowledge |
| m_addr | output | ADDR_W | Memory word address |
| m_wdata | output | DATA_W | Memory write data |
| xfer_done | output | 1 | Transfer complete |

## Verification
The bench runs several jobs with different acknowledge latencies and stream gaps. With these, a design that took a second word before the first write was acknowledged would lose data or overwrite it, and a design that moved the address or data early would write the wrong location. One job starts three words below the top of the address space. A design that did not wrap, or that carried into a wider address, would write outside the bank. After done, the bench keeps the stream valid and watches for stray requests or count changes, which catches an off-by-one stop. It also checks a zero-length job, configuration writes made mid-transfer, and a re-arm that must clear the count and done.

// File: rtl/smw_pkg.sv
// Shared constants for the stream-to-memory write adapter.
// Register offsets are word indices inside the adapter's own window.
package smw_pkg;
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] OFF_COUNT  = 2'd0;
    localparam logic [REG_AW-1:0] OFF_BASE   = 2'd1;
    localparam logic [REG_AW-1:0] OFF_LEN    = 2'd2;
    localparam logic [REG_AW-1:0] OFF_STATUS = 2'd3;
    localparam int STAT_DONE = 0;
    localparam int STAT_BUSY = 1;
endpackage

// File: rtl/smw_cfg_regs.sv
// Configuration window: holds the base address and length, produces the
// arm pulse on a length write, and muxes readback.
// Assumes: REG_DW >= ADDR_W and REG_DW >= LEN_W; writes are dropped while busy.
module smw_cfg_regs
    import smw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [LEN_W-1:0]  count,
    output logic              arm,
    output logic [LEN_W-1:0]  arm_len,
    output logic [ADDR_W-1:0] base_q,
    output logic [LEN_W-1:0]  len_q
);
    logic base_we;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata;
    assign arm     = reg_wen && (reg_addr == OFF_LEN) && !busy;
    assign base_we = reg_wen && (reg_addr == OFF_BASE) && !busy;
    assign arm_len = reg_wdata[LEN_W-1:0];

    // Holds the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
        end else begin
            if (base_we) base_q <= reg_wdata[ADDR_W-1:0];
            if (arm)     len_q  <= arm_len;
        end
    end

    // Selects read data by offset.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_COUNT: reg_rdata = REG_DW'(count);
            OFF_BASE:  reg_rdata = REG_DW'(base_q);
            OFF_LEN:   reg_rdata = REG_DW'(len_q);
            default: begin
                reg_rdata[STAT_DONE] = done;
                reg_rdata[STAT_BUSY] = busy;
            end
        endcase
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_wen |=> $stable(base_q) && $stable(len_q)); // R8
endmodule

// File: rtl/smw_wr_engine.sv
// Transfer engine: takes one stream word at a time, issues it as a memory
// write and waits for the acknowledge before taking the next word.
// Assumes: arm arrives only while idle, so no write is pending at arm time.
module smw_wr_engine #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [LEN_W-1:0]  arm_len,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_req,
    input  logic              m_ack,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  count
);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] next_addr;
    logic              take;
    logic              commit;
    logic              last;

    assign s_ready = busy && !m_req;
    assign take    = s_valid && s_ready;
    assign commit  = m_req && m_ack;
    assign last    = (count + LEN_ONE) == cfg_len;

    // Tracks busy/done state and the words-written count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            count <= '0;
        end else if (arm) begin
            busy  <= (arm_len != '0);
            done  <= (arm_len == '0);
            count <= '0;
        end else if (commit) begin
            count <= count + LEN_ONE;
            if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // Drives the memory request and steps the target address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_req     <= 1'b0;
            m_addr    <= '0;
            m_wdata   <= '0;
            next_addr <= '0;
        end else if (arm) begin
            m_req     <= 1'b0;
            next_addr <= cfg_base;
        end else if (take) begin
            m_req   <= 1'b1;
            m_addr  <= next_addr;
            m_wdata <= s_data;
        end else if (commit) begin
            m_req     <= 1'b0;
            next_addr <= next_addr + ADDR_ONE;
        end
    end

    AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> m_req && (m_wdata == $past(s_data))); // R4
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_wdata)); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> count == $past(count) + LEN_ONE); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> count < cfg_len); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !m_req && !s_ready); // R7
endmodule

// File: rtl/stream_mem_writer.sv
// Stream-to-memory write adapter top: register window plus transfer engine.
// Assumes: the memory bank acknowledges each request exactly once, and the
// window decode for this instance is done outside.
module stream_mem_writer
    import smw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_req,
    input  logic              m_ack,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic              xfer_done
);
    logic              arm;
    logic [LEN_W-1:0]  arm_len;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic              busy;
    logic [LEN_W-1:0]  count;

    smw_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_DW(REG_DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .done(xfer_done), .count(count), .arm(arm), .arm_len(arm_len),
        .base_q(base_q), .len_q(len_q)
    );

    smw_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_len(arm_len),
        .cfg_base(base_q), .cfg_len(len_q), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .m_req(m_req), .m_ack(m_ack),
        .m_addr(m_addr), .m_wdata(m_wdata), .busy(busy), .done(xfer_done),
        .count(count)
    );
endmodule

// File: tb/sim_stream_mem_writer.sv
module sim_stream_mem_writer;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 16;
    localparam int REG_DW = 32;
    localparam int NVEC   = 5;
    localparam int MAXW   = 300;

    // Vector fields: base[71:56] len[55:40] ack_delay[39:36] gap[35:32] seed[31:0]
    localparam logic [71:0] VEC [0:NVEC-1] = '{
        {16'h0100, 16'd8,   4'd0, 4'd0, 32'h0000_1000},
        {16'h0200, 16'd5,   4'd3, 4'd0, 32'hA5A5_0000},
        {16'h0000, 16'd1,   4'd1, 4'd2, 32'h1234_5678},
        {16'hFFFD, 16'd6,   4'd0, 4'd1, 32'hC0DE_0000},
        {16'h0400, 16'd256, 4'd0, 4'd0, 32'h0BAD_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wen = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [REG_DW-1:0] reg_wdata = '0;
    logic [REG_DW-1:0] reg_rdata;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [DATA_W-1:0] s_data = '0;
    logic              m_req;
    logic              m_ack;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata;
    logic              xfer_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    stream_mem_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                        .REG_DW(REG_DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .m_req(m_req), .m_ack(m_ack),
        .m_addr(m_addr), .m_wdata(m_wdata), .xfer_done(xfer_done)
    );

    always #4 clk = ~clk;

    // Memory model and monitor
    int                ack_dly = 0;
    int                wait_cnt = 0;
    logic              ack_q = 1'b0;
    int                wr_n = 0;
    logic [ADDR_W-1:0] wr_addr [0:MAXW-1];
    logic [DATA_W-1:0] wr_data [0:MAXW-1];
    int                hold_err = 0;
    int                ready_err = 0;
    logic              p_req = 1'b0, p_ack = 1'b0;
    logic [ADDR_W-1:0] p_addr = '0;
    logic [DATA_W-1:0] p_data = '0;

    assign m_ack = ack_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            wait_cnt <= 0;
        end else begin
            if (m_req && !ack_q) begin
                if (wait_cnt >= ack_dly) begin
                    ack_q    <= 1'b1;
                    wait_cnt <= 0;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end else begin
                ack_q <= 1'b0;
            end
            if (m_req && ack_q) begin
                if (wr_n < MAXW) begin
                    wr_addr[wr_n] <= m_addr;
                    wr_data[wr_n] <= m_wdata;
                end
                wr_n <= wr_n + 1;
            end
            if (p_req && !p_ack && !(m_req && m_addr == p_addr && m_wdata == p_data))
                hold_err <= hold_err + 1;
            if (m_req && s_ready) ready_err <= ready_err + 1;
        end
        p_req  <= m_req;
        p_ack  <= ack_q;
        p_addr <= m_addr;
        p_data <= m_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push_word(input logic [31:0] d, input int gap);
        bit hs;
        @(negedge clk);
        s_valid = 1'b1; s_data = d;
        hs = 1'b0;
        while (!hs) begin
            #1 hs = s_ready;
            @(negedge clk);
        end
        s_valid = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!xfer_done && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] seed, input int i);
        return seed + 32'(i) * 32'd3;
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [15:0] vb, vl;
        logic [31:0] vs;
        int gap, bad_k, base_n;
        bit okw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(!s_ready && !m_req && !xfer_done, "R1 outputs after reset",
              {29'd0, s_ready, m_req, xfer_done}, 32'd0);
        reg_read(2'd0, rd);
        check(rd == 0, "R1 count after reset", rd, 32'd0);
        reg_read(2'd3, rd);
        check(rd == 0, "R1 status after reset", rd, 32'd0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            vb = VEC[v][71:56]; vl = VEC[v][55:40];
            ack_dly = int'(VEC[v][39:36]); gap = int'(VEC[v][35:32]);
            vs = VEC[v][31:0];
            reg_write(2'd1, {16'd0, vb});
            base_n = wr_n; hold_err = 0; ready_err = 0;
            reg_write(2'd2, {16'd0, vl});
            #1;
            // R3 armed with no start bit
            check(s_ready == 1'b1, "R3 ready after length write", {31'd0, s_ready}, 32'd1);
            reg_read(2'd3, rd);
            check(rd == 32'd2, "R3 busy after arm", rd, 32'd2);
            for (int i = 0; i < int'(vl); i++) push_word(word_of(vs, i), gap);
            wait_done();
            repeat (2) @(negedge clk);
            check(wr_n - base_n == int'(vl), "R6 number of writes",
                  32'(wr_n - base_n), 32'(vl));
            okw = 1'b1; bad_k = 0;
            for (int k = 0; k < int'(vl); k++) begin
                if (okw && (wr_addr[base_n + k] != vb + 16'(k) ||
                            wr_data[base_n + k] != word_of(vs, k))) begin
                    okw = 1'b0; bad_k = k;
                end
            end
            check(okw, "R4 R6 write address/data order",
                  {wr_addr[base_n + bad_k], 16'd0}, {vb + 16'(bad_k), 16'd0});
            check(hold_err == 0 && ready_err == 0, "R5 hold and stall while pending",
                  32'(hold_err + ready_err), 32'd0);
            reg_read(2'd0, rd);
            check(rd == {16'd0, vl}, "R6 words-written count", rd, {16'd0, vl});
            reg_read(2'd3, rd);
            check(rd == 32'd1 && xfer_done, "R7 done status", rd, 32'd1);
            // R7 stream data after done is ignored
            @(negedge clk);
            s_valid = 1'b1; s_data = 32'hDEAD_BEEF;
            repeat (5) @(negedge clk);
            #1;
            check(!s_ready && wr_n - base_n == int'(vl), "R7 no write after done",
                  32'(wr_n - base_n), 32'(vl));
            s_valid = 1'b0;
            reg_read(2'd0, rd);
            check(rd == {16'd0, vl}, "R7 count frozen after done", rd, {16'd0, vl});
        end

        // R2 read-only offsets
        reg_write(2'd0, 32'h55);
        reg_write(2'd3, 32'h0);
        reg_read(2'd0, rd);
        check(rd == 32'd256, "R2 count not writable", rd, 32'd256);
        reg_read(2'd3, rd);
        check(rd == 32'd1, "R2 status not writable", rd, 32'd1);
        reg_read(2'd2, rd);
        check(rd == 32'd256, "R2 length readback", rd, 32'd256);

        // R3 zero length
        ack_dly = 0;
        base_n = wr_n;
        reg_write(2'd1, 32'h0700);
        reg_write(2'd2, 32'd0);
        @(negedge clk);
        s_valid = 1'b1; s_data = 32'h0;
        repeat (4) @(negedge clk);
        #1;
        check(xfer_done && !s_ready && wr_n == base_n, "R3 zero length done, no write",
              {30'd0, xfer_done, s_ready}, 32'd2);
        s_valid = 1'b0;

        // R8 config writes while busy, R9 re-arm
        reg_write(2'd1, 32'h0300);
        base_n = wr_n;
        reg_write(2'd2, 32'd4);
        reg_read(2'd3, rd);
        check(rd == 32'd2, "R9 re-arm clears done", rd, 32'd2);
        reg_read(2'd0, rd);
        check(rd == 32'd0, "R9 re-arm clears count", rd, 32'd0);
        push_word(32'h1, 0);
        push_word(32'h2, 0);
        reg_write(2'd1, 32'h0900);
        reg_write(2'd2, 32'd10);
        reg_read(2'd1, rd);
        check(rd == 32'h0300, "R8 base write ignored while busy", rd, 32'h0300);
        reg_read(2'd2, rd);
        check(rd == 32'd4, "R8 length write ignored while busy", rd, 32'd4);
        push_word(32'h3, 0);
        push_word(32'h4, 0);
        wait_done();
        repeat (2) @(negedge clk);
        check(wr_n - base_n == 4 && wr_addr[base_n + 3] == 16'h0303,
              "R8 transfer unaffected", {16'(wr_n - base_n), wr_addr[base_n + 3]},
              {16'd4, 16'h0303});
        reg_read(2'd0, rd);
        check(rd == 32'd4, "R8 R9 final count", rd, 32'd4);

        // R1 reset again mid-state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!xfer_done && !s_ready && !m_req, "R1 reset clears done",
              {29'd0, xfer_done, s_ready, m_req}, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule